// File: doc/BRIEF.md
# Light Sensor Integration Sequencer

This block sequences the digital side of a light-to-digital converter. A charge-balancing front end delivers one count pulse line per photodiode channel. The block collects the pulses of the selected channel over an integration window and turns the total into a conversion result. It then presents that result on a held output register, marked by a one-clock valid strobe.

The window is timed in one of two ways. In internal mode it lasts a fixed number of clock cycles, chosen by a two-bit resolution code. In external mode the host times it: each one-cycle sync command closes the running window and opens the next one. A channel selector picks channel 1 alone, channel 2 alone, or a differential pair of back-to-back windows (channel 1, then channel 2) that yields their signed difference. A fourth selector value idles the converter. A single write strobe loads the settings (run, sleep, external timing, channel selector and resolution code) and restarts the sequencer, so that no result ever mixes two settings.

Top module: `lux_seq`

## Requirements
- R1: After reset the run bit is 0, the sleep bit is 0, `res_valid` is 0 and `res_data` is 0, and no result is produced until a configuration with run = 1 is written.
- R2: A cycle with `cfg_wr` = 1 loads all settings at that clock edge and discards the window in progress, including its counts and a first differential phase. No strobe follows that write, even when the write falls in the last cycle of a window. The new window starts in the next cycle.
- R3: While run = 0 or sleep = 1, nothing is counted and `res_valid` stays 0.
- R4: In internal mode (`cfg_ext` = 0) a window lasts 2^n cycles. n comes from `cfg_res`: 00 gives 16, 01 gives 12, 10 gives 8 and 11 gives 4. Windows follow each other with no gap, and the strobe comes in the cycle after the last window cycle.
- R5: In external mode (`cfg_ext` = 1) a window runs from its start up to and including the cycle in which `sync_cmd` = 1. The next window starts in the following cycle, and the strobe comes one cycle after the sync.
- R6: In internal mode `sync_cmd` has no effect on window length or on results.
- R7: Selector 00 counts `ch1_pulse` and selector 01 counts `ch2_pulse`. The result is the unsigned pulse count of one window, saturated at 2^n - 1 and zero-extended to 16 bits.
- R8: Selector 10 runs a channel 1 window and then a channel 2 window, with a single strobe after the second. The result is count1 - count2, clamped to -2^(n-1) .. 2^(n-1)-1 and sign-extended to 16 bits as two's complement.
- R9: Selector 11 performs no conversion and never raises `res_valid`.
- R10: `res_valid` is high for exactly one clock per result, and `res_data` keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Settings write strobe; restarts the sequencer |
| cfg_run | input | 1 | Run bit: 1 converts, 0 holds the core in reset |
| cfg_sleep | input | 1 | Sleep bit: 1 halts all conversion |
| cfg_ext | input | 1 | 0 internal window timing, 1 host-timed windows |
| cfg_sel | input | 2 | Channel selector: 00 ch1, 01 ch2, 10 difference, 11 idle |
| cfg_res | input | 2 | Resolution code: 00/01/10/11 gives n = 16/12/8/4 |
| sync_cmd | input | 1 | One-cycle host sync command (external mode only) |
| ch1_pulse | input | 1 | Count pulse from channel 1 front end |
| ch2_pulse | input | 1 | Count pulse from channel 2 front end |
| res_data | output | 16 | Last conversion result |
| res_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench goes after the saturation point. A window in which every cycle pulses gives a count of exactly 2^n, one above the largest code, so a design without saturation would wrap to zero. It drives the difference past both clamp limits, where a missing clamp shows up as a wrong sign or a wrapped value, and it writes the settings in the very last cycle of a window, where a design that lets the old window finish would emit a stale strobe. Sync commands are sprinkled over internal windows to catch a design that lets them shorten the window. Back-to-back windows and held data catch a strobe that is off by one cycle or lasts too long.

// File: rtl/lux_pkg.sv
// Shared settings for the light sensor integration sequencer.
// Assumes the resolution code steps n down by STEP_BITS from MAX_BITS.
package lux_pkg;
    localparam int MAX_BITS  = 16;
    localparam int STEP_BITS = 4;

    // Channel selector values; their encoding is visible at the ports.
    typedef enum logic [1:0] {
        SEL_CH1  = 2'b00,
        SEL_CH2  = 2'b01,
        SEL_DIFF = 2'b10,
        SEL_IDLE = 2'b11
    } chan_sel_e;

    // Registered settings.
    typedef struct packed {
        logic      run;
        logic      sleep;
        logic      ext;
        chan_sel_e sel;
        logic [1:0] res;
    } cfg_t;
endpackage

// File: rtl/lux_cfg_regs.sv
// Settings register: loads every field on a write strobe and reports
// whether the converter may run. Assumes writes are single-cycle strobes.
module lux_cfg_regs
    import lux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_run,
    input  logic       cfg_sleep,
    input  logic       cfg_ext,
    input  logic [1:0] cfg_sel,
    input  logic [1:0] cfg_res,
    output cfg_t       cfg_q,
    output logic       active
);
    // Hold the settings; defaults keep the core stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{run: 1'b0, sleep: 1'b0, ext: 1'b0, sel: SEL_CH1, res: 2'b00};
        end else if (cfg_wr) begin
            cfg_q <= '{run: cfg_run, sleep: cfg_sleep, ext: cfg_ext,
                       sel: chan_sel_e'(cfg_sel), res: cfg_res};
        end
    end

    // The converter runs only when enabled, awake and given a channel.
    always_comb active = cfg_q.run && !cfg_q.sleep && (cfg_q.sel != SEL_IDLE);
endmodule

// File: rtl/lux_window_timer.sv
// Window timer: in internal mode it counts 2^n cycles per window, in
// external mode a host sync closes the window. Assumes MAX_BITS > 3*STEP_BITS.
module lux_window_timer #(
    parameter int MAX_BITS  = 16,
    parameter int STEP_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ext_mode,
    input  logic [1:0] res_code,
    input  logic       sync_cmd,
    output logic       win_end
);
    localparam logic [MAX_BITS-1:0] ALL_ONES = '1;

    logic [MAX_BITS-1:0] tcnt;
    logic [MAX_BITS-1:0] last_cnt;

    // Index of the last cycle of an internal window: 2^n - 1.
    always_comb last_cnt = ALL_ONES >> (STEP_BITS * int'(res_code));

    // Window closes on the sync (external) or on the last count (internal).
    always_comb win_end = !clear && (ext_mode ? sync_cmd : (tcnt == last_cnt));

    // Cycle counter; parked at zero in external mode or when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || win_end || ext_mode) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/lux_accum.sv
// Pulse accumulator: sums the selected channel over a window, keeps the
// first differential phase and flags when a final count is ready.
// Assumes at most one pulse per channel per clock.
module lux_accum #(
    parameter int MAX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                win_end,
    input  logic                diff_mode,
    input  logic                sel_ch2,
    input  logic                ch1_pulse,
    input  logic                ch2_pulse,
    output logic                fin,
    output logic [MAX_BITS:0]   fin_cnt,
    output logic [MAX_BITS:0]   first_cnt
);
    localparam int ACC_W = MAX_BITS + 1;

    logic [ACC_W-1:0] acc;
    logic             phase_b;
    logic             pulse;

    // Pick the channel: fixed, or channel 2 during the second phase.
    always_comb pulse = (sel_ch2 || (diff_mode && phase_b)) ? ch2_pulse : ch1_pulse;

    // Count including this cycle, saturating at all ones.
    always_comb fin_cnt = (&acc) ? acc : acc + {{(ACC_W-1){1'b0}}, pulse};

    // A result is ready at every window end except the first phase.
    always_comb fin = win_end && !(diff_mode && !phase_b);

    // Accumulate, and on a window end restart and advance the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            acc       <= '0;
            phase_b   <= 1'b0;
            first_cnt <= '0;
        end else if (win_end) begin
            acc <= '0;
            if (diff_mode && !phase_b) begin
                first_cnt <= fin_cnt;
                phase_b   <= 1'b1;
            end else begin
                phase_b   <= 1'b0;
            end
        end else begin
            acc <= fin_cnt;
        end
    end
endmodule

// File: rtl/lux_result.sv
// Result stage: saturates single-channel counts, clamps differences to
// the signed range of the resolution, and registers data and strobe.
module lux_result #(
    parameter int MAX_BITS  = 16,
    parameter int STEP_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fin,
    input  logic                diff_mode,
    input  logic [1:0]          res_code,
    input  logic [MAX_BITS:0]   fin_cnt,
    input  logic [MAX_BITS:0]   first_cnt,
    output logic [MAX_BITS-1:0] res_data,
    output logic                res_valid
);
    localparam int ACC_W = MAX_BITS + 1;
    localparam logic [ACC_W-1:0] CAP_TOP = {1'b0, {MAX_BITS{1'b1}}};

    logic [ACC_W-1:0]        umax;
    logic [MAX_BITS-1:0]     single_val;
    logic signed [ACC_W:0]   diff_raw;
    logic signed [ACC_W:0]   pos_lim;
    logic signed [ACC_W:0]   neg_lim;
    logic [MAX_BITS-1:0]     diff_val;
    logic [MAX_BITS-1:0]     next_data;

    // Format the finished count as saturated unsigned or clamped signed.
    always_comb begin
        umax       = CAP_TOP >> (STEP_BITS * int'(res_code));
        single_val = (fin_cnt > umax) ? umax[MAX_BITS-1:0] : fin_cnt[MAX_BITS-1:0];
        diff_raw   = $signed({1'b0, first_cnt}) - $signed({1'b0, fin_cnt});
        pos_lim    = $signed({2'b00, umax[ACC_W-1:1]});
        neg_lim    = ~pos_lim;
        if (diff_raw > pos_lim) begin
            diff_val = pos_lim[MAX_BITS-1:0];
        end else if (diff_raw < neg_lim) begin
            diff_val = neg_lim[MAX_BITS-1:0];
        end else begin
            diff_val = diff_raw[MAX_BITS-1:0];
        end
        next_data = diff_mode ? diff_val : single_val;
    end

    // Register the strobe every cycle and the data only on a new result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= fin;
            if (fin) begin
                res_data <= next_data;
            end
        end
    end
endmodule

// File: rtl/lux_seq.sv
// Light sensor integration sequencer top: settings register, window
// timer, accumulator and result stage. Any settings write aborts the
// running window.
module lux_seq
    import lux_pkg::*;
#(
    parameter int MAX_BITS  = lux_pkg::MAX_BITS,
    parameter int STEP_BITS = lux_pkg::STEP_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_run,
    input  logic                cfg_sleep,
    input  logic                cfg_ext,
    input  logic [1:0]          cfg_sel,
    input  logic [1:0]          cfg_res,
    input  logic                sync_cmd,
    input  logic                ch1_pulse,
    input  logic                ch2_pulse,
    output logic [MAX_BITS-1:0] res_data,
    output logic                res_valid
);
    cfg_t              cfg_q;
    logic              active;
    logic              abort;
    logic              win_end;
    logic              fin;
    logic              diff_mode;
    logic              sel_ch2;
    logic [1:0]        sel_q;
    logic [1:0]        res_q;
    logic [MAX_BITS:0] fin_cnt;
    logic [MAX_BITS:0] first_cnt;

    // Decode the registered settings for the datapath.
    always_comb begin
        abort     = cfg_wr || !active;
        diff_mode = (cfg_q.sel == SEL_DIFF);
        sel_ch2   = (cfg_q.sel == SEL_CH2);
        sel_q     = cfg_q.sel;
        res_q     = cfg_q.res;
    end

    lux_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_run   (cfg_run),
        .cfg_sleep (cfg_sleep),
        .cfg_ext   (cfg_ext),
        .cfg_sel   (cfg_sel),
        .cfg_res   (cfg_res),
        .cfg_q     (cfg_q),
        .active    (active)
    );

    lux_window_timer #(.MAX_BITS(MAX_BITS), .STEP_BITS(STEP_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (abort),
        .ext_mode (cfg_q.ext),
        .res_code (res_q),
        .sync_cmd (sync_cmd),
        .win_end  (win_end)
    );

    lux_accum #(.MAX_BITS(MAX_BITS)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .win_end   (win_end),
        .diff_mode (diff_mode),
        .sel_ch2   (sel_ch2),
        .ch1_pulse (ch1_pulse),
        .ch2_pulse (ch2_pulse),
        .fin       (fin),
        .fin_cnt   (fin_cnt),
        .first_cnt (first_cnt)
    );

    lux_result #(.MAX_BITS(MAX_BITS), .STEP_BITS(STEP_BITS)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (fin),
        .diff_mode (diff_mode),
        .res_code  (res_q),
        .fin_cnt   (fin_cnt),
        .first_cnt (first_cnt),
        .res_data  (res_data),
        .res_valid (res_valid)
    );
endmodule

// File: rtl/lux_seq_chk.sv
// Property checker for lux_seq, attached through bind.
module lux_seq_chk #(
    parameter int MAX_BITS  = 16,
    parameter int STEP_BITS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr,
    input logic                active,
    input logic [1:0]          sel_q,
    input logic [1:0]          res_q,
    input logic [MAX_BITS-1:0] res_data,
    input logic                res_valid
);
    localparam logic [MAX_BITS-1:0] ALL_ONES = '1;

    logic                seen;
    logic [MAX_BITS-1:0] umax;
    logic [MAX_BITS-1:0] slim;

    // Marks cycles whose previous sample was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Limits for the current resolution.
    always_comb begin
        umax = ALL_ONES >> (STEP_BITS * int'(res_q));
        slim = umax >> 1;
    end

    assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !res_valid);

    assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !res_valid);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sel_q != 2'b10) |-> (res_data <= umax));

    assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sel_q == 2'b10) |->
            ($signed(res_data) <= $signed(slim) && $signed(res_data) >= $signed(~slim)));

    assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'b11) |=> !res_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !res_valid) |-> $stable(res_data));
endmodule

bind lux_seq lux_seq_chk #(.MAX_BITS(MAX_BITS), .STEP_BITS(STEP_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .active    (active),
    .sel_q     (sel_q),
    .res_q     (res_q),
    .res_data  (res_data),
    .res_valid (res_valid)
);

// File: tb/lux_seq_test.sv
module lux_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_run = 1'b0, cfg_sleep = 1'b0, cfg_ext = 1'b0;
    logic [1:0]  cfg_sel = 2'b00, cfg_res = 2'b00;
    logic        sync_cmd = 1'b0, ch1_pulse = 1'b0, ch2_pulse = 1'b0;
    logic [15:0] res_data;
    logic        res_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lux_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_run(cfg_run),
        .cfg_sleep(cfg_sleep), .cfg_ext(cfg_ext), .cfg_sel(cfg_sel),
        .cfg_res(cfg_res), .sync_cmd(sync_cmd), .ch1_pulse(ch1_pulse),
        .ch2_pulse(ch2_pulse), .res_data(res_data), .res_valid(res_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_single(input int cnt, input int code);
        int m = (1 << (16 - 4 * code)) - 1;
        return (cnt > m) ? m : cnt;
    endfunction

    function automatic int exp_diff(input int a, input int b, input int code);
        int n  = 16 - 4 * code;
        int hi = (1 << (n - 1)) - 1;
        int lo = -(1 << (n - 1));
        int d  = a - b;
        if (d > hi) d = hi;
        if (d < lo) d = lo;
        return d & 16'hFFFF;
    endfunction

    task automatic cfg_write(input bit run, input bit sleep, input bit ext,
                             input logic [1:0] sel, input logic [1:0] res);
        cfg_run = run; cfg_sleep = sleep; cfg_ext = ext;
        cfg_sel = sel; cfg_res = res; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Drives len cycles; a strobe is allowed only after the last one.
    task automatic run_win(input int len, input int dens, input bit ext_sync,
                           input bit rand_sync, input bit want_valid,
                           input string tag, output int c1, output int c2);
        logic [15:0] held = res_data;
        bit early = 1'b0;
        bit moved = 1'b0;
        bit last_ok = 1'b1;
        c1 = 0; c2 = 0;
        for (int i = 0; i < len; i++) begin
            ch1_pulse = ($urandom_range(99) < dens);
            ch2_pulse = ($urandom_range(99) < dens);
            sync_cmd  = ext_sync ? (i == len - 1) : (rand_sync ? $urandom_range(3) == 0 : 1'b0);
            c1 += ch1_pulse;
            c2 += ch2_pulse;
            @(negedge clk);
            if (i == len - 1 && want_valid) begin
                last_ok = res_valid;
            end else begin
                if (res_valid) early = 1'b1;
                if (res_data !== held) moved = 1'b1;
            end
        end
        ch1_pulse = 1'b0; ch2_pulse = 1'b0; sync_cmd = 1'b0;
        chk(!early && last_ok, {tag, " strobe timing"}, early, 0);
        chk(!moved, "R10 data held between strobes", moved, 0);
    endtask

    task automatic run_dir(input int l1, input int l2, input int d1, input int d2,
                           input bit ext, input int code, input string tag);
        int a1, a2, b1, b2;
        run_win(l1, d1, ext, 1'b0, 1'b0, tag, a1, a2);
        run_win(l2, d2, ext, 1'b0, 1'b1, tag, b1, b2);
        chk(res_data === 16'(exp_diff(a1, b2, code)), tag, res_data, exp_diff(a1, b2, code));
    endtask

    initial begin
        int c1, c2, len, code, sel, dens;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(res_valid === 1'b0 && res_data === 16'h0, "R1 reset outputs", res_data, 0);
        run_win(40, 90, 1'b0, 1'b1, 1'b0, "R1 idle after reset", c1, c2);

        // R4 R7: 16-cycle windows, back to back, then saturation
        cfg_write(1, 0, 0, 2'b00, 2'b11);
        run_win(16, 50, 1'b0, 1'b0, 1'b1, "R4 16-cycle window", c1, c2);
        chk(res_data === 16'(exp_single(c1, 3)), "R7 ch1 count", res_data, exp_single(c1, 3));
        run_win(16, 100, 1'b0, 1'b0, 1'b1, "R4 back to back", c1, c2);
        chk(res_data === 16'd15, "R7 saturate at 2^n-1", res_data, 15);

        // R6: syncs ignored in internal mode
        run_win(16, 40, 1'b0, 1'b1, 1'b1, "R6 sync ignored", c1, c2);
        chk(res_data === 16'(exp_single(c1, 3)), "R6 count unaffected", res_data, exp_single(c1, 3));

        // R7 channel 2 with 256-cycle windows
        cfg_write(1, 0, 0, 2'b01, 2'b10);
        run_win(256, 60, 1'b0, 1'b0, 1'b1, "R4 256-cycle window", c1, c2);
        chk(res_data === 16'(exp_single(c2, 2)), "R7 ch2 count", res_data, exp_single(c2, 2));
        cfg_write(1, 0, 0, 2'b00, 2'b01);
        run_win(4096, 30, 1'b0, 1'b0, 1'b1, "R4 4096-cycle window", c1, c2);
        chk(res_data === 16'(exp_single(c1, 1)), "R7 ch1 n=12", res_data, exp_single(c1, 1));
        cfg_write(1, 0, 0, 2'b01, 2'b00);
        run_win(65536, 30, 1'b0, 1'b0, 1'b1, "R4 65536-cycle window", c1, c2);
        chk(res_data === 16'(exp_single(c2, 0)), "R7 ch2 n=16", res_data, exp_single(c2, 0));

        // R8: differential clamps and random
        cfg_write(1, 0, 0, 2'b10, 2'b11);
        run_dir(16, 16, 100, 0, 1'b0, 3, "R8 clamp high");
        chk(res_data === 16'h0007, "R8 positive limit", res_data, 7);
        run_dir(16, 16, 0, 100, 1'b0, 3, "R8 clamp low");
        chk(res_data === 16'hFFF8, "R8 negative limit", res_data, 16'hFFF8);
        cfg_write(1, 0, 0, 2'b10, 2'b01);
        run_dir(4096, 4096, 50, 50, 1'b0, 1, "R8 diff n=12");

        // R5: external windows
        cfg_write(1, 0, 1, 2'b00, 2'b00);
        for (int k = 0; k < 6; k++) begin
            len = 1 + $urandom_range(299);
            run_win(len, 50, 1'b1, 1'b0, 1'b1, "R5 sync window", c1, c2);
            chk(res_data === 16'(c1), "R5 ext ch1 count", res_data, c1);
        end
        cfg_write(1, 0, 1, 2'b01, 2'b11);
        run_win(40, 100, 1'b1, 1'b0, 1'b1, "R5 long ext window", c1, c2);
        chk(res_data === 16'd15, "R7 ext saturate", res_data, 15);
        run_win(1, 100, 1'b1, 1'b0, 1'b1, "R5 one-cycle window", c1, c2);
        chk(res_data === 16'd1, "R5 sync cycle counted", res_data, 1);
        cfg_write(1, 0, 1, 2'b10, 2'b10);
        run_dir(30, 50, 70, 40, 1'b1, 2, "R8 ext diff");

        // R2: abort mid window and in the last cycle
        cfg_write(1, 0, 0, 2'b00, 2'b11);
        run_win(10, 100, 1'b0, 1'b0, 1'b0, "R2 partial", c1, c2);
        cfg_write(1, 0, 0, 2'b00, 2'b11);
        chk(res_valid === 1'b0, "R2 no strobe after write", res_valid, 0);
        run_win(16, 30, 1'b0, 1'b0, 1'b1, "R2 fresh window", c1, c2);
        chk(res_data === 16'(exp_single(c1, 3)), "R2 fresh count", res_data, exp_single(c1, 3));
        run_win(15, 100, 1'b0, 1'b0, 1'b0, "R2 near end", c1, c2);
        cfg_write(1, 0, 0, 2'b00, 2'b11);
        chk(res_valid === 1'b0, "R2 write in last cycle", res_valid, 0);
        cfg_write(1, 0, 0, 2'b10, 2'b11);
        run_win(16, 100, 1'b0, 1'b0, 1'b0, "R2 diff phase one", c1, c2);
        cfg_write(1, 0, 0, 2'b10, 2'b11);
        run_dir(16, 16, 0, 0, 1'b0, 3, "R2 phase discarded");
        chk(res_data === 16'h0000, "R2 first phase dropped", res_data, 0);

        // R3 R9: halted and idle settings
        cfg_write(0, 0, 0, 2'b00, 2'b11);
        run_win(50, 100, 1'b0, 1'b0, 1'b0, "R3 disabled", c1, c2);
        cfg_write(1, 1, 1, 2'b00, 2'b11);
        run_win(50, 100, 1'b1, 1'b0, 1'b0, "R3 sleeping", c1, c2);
        cfg_write(1, 0, 0, 2'b11, 2'b11);
        run_win(50, 100, 1'b0, 1'b0, 1'b0, "R9 idle selector", c1, c2);

        // Random mix of internal settings
        for (int k = 0; k < 20; k++) begin
            code = 2 + $urandom_range(1);
            sel  = $urandom_range(2);
            dens = $urandom_range(100);
            len  = 1 << (16 - 4 * code);
            cfg_write(1, 0, 0, 2'(sel), 2'(code));
            if (sel == 2) begin
                run_dir(len, len, dens, $urandom_range(100), 1'b0, code, "R8 random diff");
            end else begin
                run_win(len, dens, 1'b0, 1'b1, 1'b1, "R4 random window", c1, c2);
                chk(res_data === 16'(exp_single(sel == 1 ? c2 : c1, code)), "R7 random count",
                    res_data, exp_single(sel == 1 ? c2 : c1, code));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule